// File: doc/BRIEF.md
# SPI Flow Control Gate

This block sits beside the shift engine of an SPI master and lets a slave pause a transfer. The slave signals "wait" on a ready/busy line. For reads that line is always MISO. For writes it is MISO or a separate interrupt input, chosen by configuration. Each direction has its own enable and its own active level. Both candidate lines pass through a synchronizer before any decision uses them. The decision to pause is taken only at a byte boundary that the shift engine reports. While paused, the gate holds the serial clock at its idle level. It also tells the shift engine to drive MOSI to a fixed level that marks the direction of the transfer, and that level can be inverted.

A small state machine tracks the transfer. The states are FC_IDLE (no transfer), FC_RUN (transfer in progress, bytes flowing) and FC_HOLD (transfer paused). The transitions are:
- FC_IDLE to FC_RUN when `xfer_active` rises.
- FC_RUN to FC_HOLD at a byte boundary while a synchronized request is present and the current direction is enabled.
- FC_HOLD to FC_RUN when the request goes away or the enable is cleared.
- FC_RUN or FC_HOLD to FC_IDLE when `xfer_active` falls.

The shift register and the chip-select logic lie outside this block.

Top module: `spi_fc_gate`

## Requirements
- R1: After reset, `stall` and `mosi_force_en` are 0 and `sclk_out` equals `sclk_raw`.
- R2: MISO and the interrupt input each pass through a two-stage synchronizer. A level applied before rising edge k first affects a pause decision at rising edge k+2, so `stall` can rise no earlier than after edge k+2.
- R3: With `dir_write`=1, the request comes from `irq_in` when `wr_src_irq`=1 and from `miso_in` when `wr_src_irq`=0. With `dir_write`=0, the request always comes from `miso_in`, and `irq_in` has no effect.
- R4: With `wr_pol_low`=0 (writes) or `rd_pol_low`=0 (reads), a high source level requests a pause. With the bit set to 1, a low level requests it.
- R5: The gate enters FC_HOLD only at a rising edge where `byte_boundary`=1, the current direction is enabled and a synchronized request is present. A request seen without a boundary never raises `stall`.
- R6: In FC_HOLD, the first edge that sees the synchronized request inactive returns the gate to FC_RUN. Any edge with `xfer_active`=0 returns the gate to FC_IDLE. `stall` falls with the state change.
- R7: `stall` is 0 whenever the enable for the current direction (`fc_wr_en` for writes, `fc_rd_en` for reads) is 0. This takes effect in the same cycle, and the next edge leaves FC_HOLD.
- R8: While `stall`=1, `mosi_force_en`=1 and `mosi_force_val` is 0 for reads and 1 for writes. With `mosi_inv`=1 these levels are swapped.
- R9: While `stall`=1, `sclk_out` equals `cpol`. Otherwise `sclk_out` equals `sclk_raw`.
- R10: FC_IDLE moves only to FC_RUN, on an edge with `xfer_active`=1. A pause therefore needs at least one further edge after the transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_active | input | 1 | A transfer is in progress |
| dir_write | input | 1 | Current transfer direction: 1 write, 0 read |
| byte_boundary | input | 1 | Shift engine is between two bytes |
| sclk_raw | input | 1 | Serial clock produced by the shift engine |
| miso_in | input | 1 | Slave data line, also a ready/busy source |
| irq_in | input | 1 | Dedicated slave ready/busy line |
| fc_rd_en | input | 1 | Enable pausing on reads |
| fc_wr_en | input | 1 | Enable pausing on writes |
| wr_src_irq | input | 1 | Write request source: 1 `irq_in`, 0 `miso_in` |
| wr_pol_low | input | 1 | Write request active level: 1 low, 0 high |
| rd_pol_low | input | 1 | Read request active level: 1 low, 0 high |
| mosi_inv | input | 1 | Swap the direction marker level on MOSI |
| cpol | input | 1 | Idle level of the serial clock |
| stall | output | 1 | Pause request to the shift engine |
| mosi_force_en | output | 1 | Drive MOSI from `mosi_force_val` |
| mosi_force_val | output | 1 | Direction marker level for MOSI |
| sclk_out | output | 1 | Gated serial clock |

## Verification
A state register stuck in FC_HOLD keeps `sclk_out` at `cpol` and `mosi_force_en` high. This shows on the first cycle after the request clears. A missed entry leaves the clock running one cycle after the boundary edge. A synchronizer that is one stage too short or too long moves the rising edge of `stall` by exactly one clock. A swapped source or polarity raises `stall` for the wrong line level. The bench keeps a behavioural model in step with the design and compares every output each cycle, so any of these faults is reported in the cycle where it first becomes visible.

// File: rtl/spi_fc_pkg.sv
package spi_fc_pkg;

    typedef enum logic [1:0] {
        FC_IDLE = 2'd0,
        FC_RUN  = 2'd1,
        FC_HOLD = 2'd2
    } fc_state_e;

    // Selection settings used to form the pause request
    typedef struct packed {
        logic rd_en;
        logic wr_en;
        logic wr_src_irq;
        logic wr_pol_low;
        logic rd_pol_low;
    } fc_sel_cfg_t;

    localparam int FC_SRC_MISO = 0;
    localparam int FC_SRC_IRQ  = 1;
    localparam int FC_NUM_SRC  = 2;

endpackage

// File: rtl/spi_fc_sync.sv
module spi_fc_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[LAST];

endmodule

// File: rtl/spi_fc_req.sv
module spi_fc_req
    import spi_fc_pkg::*;
(
    input  logic        miso_s,
    input  logic        irq_s,
    input  logic        dir_write,
    input  fc_sel_cfg_t cfg,
    output logic        req,
    output logic        dir_en
);
    logic wr_level;
    logic wr_req;
    logic rd_req;

    always_comb begin
        wr_level = cfg.wr_src_irq ? irq_s : miso_s;
        wr_req   = wr_level ^ cfg.wr_pol_low;
        rd_req   = miso_s ^ cfg.rd_pol_low;
        req      = dir_write ? wr_req : rd_req;
        dir_en   = dir_write ? cfg.wr_en : cfg.rd_en;
    end

endmodule

// File: rtl/spi_fc_fsm.sv
module spi_fc_fsm
    import spi_fc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_active,
    input  logic byte_boundary,
    input  logic req,
    input  logic dir_en,
    output logic in_hold,
    output logic hold_out
);
    fc_state_e state_q;
    fc_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FC_IDLE: begin
                if (xfer_active) state_d = FC_RUN;
            end
            FC_RUN: begin
                if (!xfer_active)                          state_d = FC_IDLE;
                else if (byte_boundary && req && dir_en)   state_d = FC_HOLD;
            end
            FC_HOLD: begin
                if (!xfer_active)          state_d = FC_IDLE;
                else if (!req || !dir_en)  state_d = FC_RUN;
            end
            default: state_d = FC_IDLE;
        endcase
    end

    always_comb begin
        in_hold  = (state_q == FC_HOLD);
        hold_out = in_hold && dir_en;
    end

endmodule

// File: rtl/spi_fc_gate.sv
module spi_fc_gate
    import spi_fc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_active,
    input  logic dir_write,
    input  logic byte_boundary,
    input  logic sclk_raw,
    input  logic miso_in,
    input  logic irq_in,
    input  logic fc_rd_en,
    input  logic fc_wr_en,
    input  logic wr_src_irq,
    input  logic wr_pol_low,
    input  logic rd_pol_low,
    input  logic mosi_inv,
    input  logic cpol,
    output logic stall,
    output logic mosi_force_en,
    output logic mosi_force_val,
    output logic sclk_out
);
    logic [FC_NUM_SRC-1:0] src_raw;
    logic [FC_NUM_SRC-1:0] src_sync;
    fc_sel_cfg_t           sel_cfg;
    logic                  req;
    logic                  dir_en;
    logic                  in_hold;
    logic                  hold;

    assign src_raw[FC_SRC_MISO] = miso_in;
    assign src_raw[FC_SRC_IRQ]  = irq_in;

    assign sel_cfg = '{rd_en:      fc_rd_en,
                       wr_en:      fc_wr_en,
                       wr_src_irq: wr_src_irq,
                       wr_pol_low: wr_pol_low,
                       rd_pol_low: rd_pol_low};

    spi_fc_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (FC_NUM_SRC)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (src_raw),
        .q     (src_sync)
    );

    spi_fc_req u_req (
        .miso_s    (src_sync[FC_SRC_MISO]),
        .irq_s     (src_sync[FC_SRC_IRQ]),
        .dir_write (dir_write),
        .cfg       (sel_cfg),
        .req       (req),
        .dir_en    (dir_en)
    );

    spi_fc_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .xfer_active   (xfer_active),
        .byte_boundary (byte_boundary),
        .req           (req),
        .dir_en        (dir_en),
        .in_hold       (in_hold),
        .hold_out      (hold)
    );

    always_comb begin
        stall          = hold;
        mosi_force_en  = hold;
        mosi_force_val = dir_write ^ mosi_inv;
        sclk_out       = hold ? cpol : sclk_raw;
    end

endmodule

// File: rtl/spi_fc_gate_chk.sv
module spi_fc_gate_chk (
    input logic clk,
    input logic rst_n,
    input logic xfer_active,
    input logic dir_write,
    input logic byte_boundary,
    input logic fc_rd_en,
    input logic fc_wr_en,
    input logic mosi_inv,
    input logic cpol,
    input logic stall,
    input logic mosi_force_en,
    input logic mosi_force_val,
    input logic sclk_out,
    input logic in_hold
);
    logic cur_en;
    assign cur_en = dir_write ? fc_wr_en : fc_rd_en;

    assert_gate_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_en |-> !stall);

    assert_entry_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_hold) |-> $past(byte_boundary));

    assert_entry_after_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_hold) |-> $past(xfer_active));

    assert_leave_on_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_hold && !xfer_active |=> !in_hold);

    assert_mosi_marker_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (mosi_force_en && ((mosi_force_val ^ mosi_inv) == dir_write)));

    assert_sclk_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (sclk_out == cpol));

endmodule

bind spi_fc_gate spi_fc_gate_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .xfer_active    (xfer_active),
    .dir_write      (dir_write),
    .byte_boundary  (byte_boundary),
    .fc_rd_en       (fc_rd_en),
    .fc_wr_en       (fc_wr_en),
    .mosi_inv       (mosi_inv),
    .cpol           (cpol),
    .stall          (stall),
    .mosi_force_en  (mosi_force_en),
    .mosi_force_val (mosi_force_val),
    .sclk_out       (sclk_out),
    .in_hold        (in_hold)
);

// File: tb/spi_fc_gate_tb.sv
`timescale 1ns/1ps
module spi_fc_gate_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xfer_active = 0, dir_write = 0, byte_boundary = 0, sclk_raw = 0;
    logic miso_in = 0, irq_in = 0, fc_rd_en = 0, fc_wr_en = 0, wr_src_irq = 0;
    logic wr_pol_low = 0, rd_pol_low = 0, mosi_inv = 0, cpol = 0;
    logic stall, mosi_force_en, mosi_force_val, sclk_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // behavioural model state
    bit m_hist [$];   // miso samples, newest at front
    bit i_hist [$];   // irq samples, newest at front
    int m_state = 0;  // 0 idle, 1 running, 2 paused

    always #2.5 clk = ~clk;

    spi_fc_gate u_dut (
        .clk(clk), .rst_n(rst_n), .xfer_active(xfer_active), .dir_write(dir_write),
        .byte_boundary(byte_boundary), .sclk_raw(sclk_raw), .miso_in(miso_in),
        .irq_in(irq_in), .fc_rd_en(fc_rd_en), .fc_wr_en(fc_wr_en),
        .wr_src_irq(wr_src_irq), .wr_pol_low(wr_pol_low), .rd_pol_low(rd_pol_low),
        .mosi_inv(mosi_inv), .cpol(cpol), .stall(stall),
        .mosi_force_en(mosi_force_en), .mosi_force_val(mosi_force_val),
        .sclk_out(sclk_out)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit cur_en();
        return dir_write ? fc_wr_en : fc_rd_en;
    endfunction

    // level seen two edges ago (zero before enough history)
    function automatic bit old2(ref bit h [$]);
        return (h.size() >= 2) ? h[1] : 1'b0;
    endfunction

    task automatic model_edge();
        bit ms, is, lvl, rq, en;
        if (!rst_n) begin
            m_state = 0;
            m_hist.delete();
            i_hist.delete();
        end else begin
            ms  = old2(m_hist);
            is  = old2(i_hist);
            lvl = wr_src_irq ? is : ms;
            rq  = dir_write ? (lvl ^ wr_pol_low) : (ms ^ rd_pol_low);
            en  = cur_en();
            case (m_state)
                0: if (xfer_active) m_state = 1;
                1: if (!xfer_active) m_state = 0;
                   else if (byte_boundary && rq && en) m_state = 2;
                default: if (!xfer_active) m_state = 0;
                         else if (!rq || !en) m_state = 1;
            endcase
            m_hist.push_front(miso_in);
            i_hist.push_front(irq_in);
            if (m_hist.size() > 4) void'(m_hist.pop_back());
            if (i_hist.size() > 4) void'(i_hist.pop_back());
        end
    endtask

    task automatic compare_all();
        bit e_stall;
        e_stall = (m_state == 2) && cur_en();
        chk(stall, e_stall, "R6 stall vs model");
        chk(mosi_force_en, e_stall, "R8 force enable vs model");
        chk(mosi_force_val, dir_write ^ mosi_inv, "R8 marker level vs model");
        chk(sclk_out, e_stall ? cpol : sclk_raw, "R9 sclk vs model");
    endtask

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            compare_all();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        sclk_raw = 1'b1;
        #0.1;
        chk(stall, 1'b0, "R1 stall after reset");
        chk(mosi_force_en, 1'b0, "R1 force enable after reset");
        chk(sclk_out, 1'b1, "R1 sclk follows raw");
        step(1);

        // R10: start from idle with request already synchronized
        dir_write = 1; fc_wr_en = 1; miso_in = 1; byte_boundary = 1;
        step(3);
        xfer_active = 1;
        step(1);
        chk(stall, 1'b0, "R10 idle goes to run first");
        step(1);
        chk(stall, 1'b1, "R10 pause one edge after start");
        xfer_active = 0;
        step(1);
        chk(stall, 1'b0, "R6 end of transfer releases");

        // R2: synchronizer latency
        miso_in = 0; step(3);
        xfer_active = 1; step(1);
        miso_in = 1;
        step(1);
        chk(stall, 1'b0, "R2 edge one");
        step(1);
        chk(stall, 1'b0, "R2 edge two");
        step(1);
        chk(stall, 1'b1, "R2 edge three");

        // R6: request drop releases after synchronizer
        miso_in = 0;
        step(2);
        chk(stall, 1'b1, "R6 still paused");
        step(1);
        chk(stall, 1'b0, "R6 released");

        // R5: request without boundary
        byte_boundary = 0; miso_in = 1;
        step(4);
        chk(stall, 1'b0, "R5 no boundary no pause");
        byte_boundary = 1;
        step(1);
        chk(stall, 1'b1, "R5 boundary pauses");
        miso_in = 0; byte_boundary = 0;
        step(3);

        // R3: source selection
        wr_src_irq = 1; miso_in = 1; irq_in = 0; byte_boundary = 1;
        step(3);
        chk(stall, 1'b0, "R3 miso ignored with irq source");
        irq_in = 1;
        step(3);
        chk(stall, 1'b1, "R3 irq source pauses");
        irq_in = 0;
        step(3);
        dir_write = 0; fc_rd_en = 1; miso_in = 0; irq_in = 1;
        step(4);
        chk(stall, 1'b0, "R3 irq ignored on reads");

        // R4: polarity
        rd_pol_low = 1;
        step(1);
        chk(stall, 1'b1, "R4 read low level pauses");
        miso_in = 1;
        step(3);
        chk(stall, 1'b0, "R4 read high level releases");
        byte_boundary = 0; rd_pol_low = 0; miso_in = 0;
        step(3);
        dir_write = 1; wr_src_irq = 0; wr_pol_low = 1; irq_in = 0; byte_boundary = 1;
        step(1);
        chk(stall, 1'b1, "R4 write low level pauses");
        miso_in = 1;
        step(3);
        chk(stall, 1'b0, "R4 write high level releases");
        byte_boundary = 0; wr_pol_low = 0; miso_in = 0;
        step(3);

        // R7: enable gating
        miso_in = 1; byte_boundary = 1;
        step(3);
        chk(stall, 1'b1, "R7 paused before clear");
        fc_wr_en = 0;
        #0.5;
        chk(stall, 1'b0, "R7 immediate release");
        step(1);
        fc_wr_en = 1; byte_boundary = 0;
        #0.5;
        chk(stall, 1'b0, "R7 state left pause");
        step(1);
        fc_wr_en = 0; byte_boundary = 1;
        step(2);
        chk(stall, 1'b0, "R7 disabled at boundary");

        // R8 / R9: marker and clock during pause
        fc_wr_en = 1;
        step(1);
        chk(mosi_force_en, 1'b1, "R8 force enabled");
        chk(mosi_force_val, 1'b1, "R8 write marker");
        mosi_inv = 1; #0.5;
        chk(mosi_force_val, 1'b0, "R8 write marker inverted");
        cpol = 1; sclk_raw = 0; #0.5;
        chk(sclk_out, 1'b1, "R9 held high");
        cpol = 0; sclk_raw = 1; #0.5;
        chk(sclk_out, 1'b0, "R9 held low");
        dir_write = 0; mosi_inv = 0; #0.5;
        chk(mosi_force_val, 1'b0, "R8 read marker");
        mosi_inv = 1; #0.5;
        chk(mosi_force_val, 1'b1, "R8 read marker inverted");
        xfer_active = 0;
        step(1);
        chk(sclk_out, 1'b1, "R9 raw clock after pause");

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            xfer_active   = ($urandom_range(0, 15) != 0);
            dir_write     = $urandom_range(0, 1);
            byte_boundary = ($urandom_range(0, 3) == 0);
            sclk_raw      = $urandom_range(0, 1);
            miso_in       = $urandom_range(0, 1);
            irq_in        = $urandom_range(0, 1);
            fc_rd_en      = ($urandom_range(0, 7) != 0);
            fc_wr_en      = ($urandom_range(0, 7) != 0);
            if ($urandom_range(0, 31) == 0) begin
                wr_src_irq = $urandom_range(0, 1);
                wr_pol_low = $urandom_range(0, 1);
                rd_pol_low = $urandom_range(0, 1);
                mosi_inv   = $urandom_range(0, 1);
                cpol       = $urandom_range(0, 1);
            end
            step(1);
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule